// File: doc/BRIEF.md
# DAC Waveform Sequencer

This block turns a short table of sample offsets and a DC level into a stream of DAC output codes. Each update tick it moves one step along a pattern built from forward and reverse walks over the offset table. In each walk it adds the offset to the DC level or subtracts it. The result is written into a DAC output register. A host programs the offset table, the DC level (the input register) and a control word. The host can also write the output register directly, which bypasses the sequencing.

The control word holds the table length and four mode bits. Enable lets ticks advance the sequence. Symmetric appends a mirrored return walk. Bipolar appends walks that subtract the offsets. Continuous makes the pattern loop instead of stopping on its last value. Sums are clamped to the unsigned code range. After a control write, the first tick emits the plain DC level, and the pattern follows from the next tick.

Top module: `dac_wave_seq`

## Requirements
- R1: After reset the output code is 0, all modes are off, and the table and the DC level are 0.
- R2: Ticks change the output only while the enable bit (ctrl_mode bit 0) is set. After any control write, the first enabled tick outputs the DC level unchanged.
- R3: The ticks after that output DC + offset[i] for i = 0 up to N-1, where N = ctrl_len_m1 + 1.
- R4: With the symmetric bit (bit 1) set, the forward walk is followed by DC + offset[i] for i = N-2 down to 0, so the peak is not output twice.
- R5: With symmetric and bipolar (bit 2) both set, the pattern continues with DC - offset[i] for i = 0 up to N-1 and then for i = N-2 down to 0. The last value of the mirrored walk is not output again.
- R6: With bipolar set and symmetric clear, the forward walk is followed by DC - offset[i] for i = N-1 down to 0, so the last table entry is used twice.
- R7: With continuous (bit 3) clear, the output holds its last pattern value once the pattern ends. With it set, the pattern restarts at the forward walk without repeating its final value. In symmetric non-bipolar mode with N >= 2, the restart therefore begins at index 1.
- R8: A table write (fifo_we, entry fifo_waddr) is ignored while the enable bit is set.
- R9: A control write restarts sequencing. When a control write and a tick fall in the same cycle, the tick is dropped.
- R10: An input-register write takes effect on the next sequence step. It does not restart the pattern. A tick in the same cycle still uses the old level.
- R11: An output-register write sets the output on the next clock edge and does not disturb the sequence position. If a tick falls in the same cycle, the step is consumed but the written value wins.
- R12: Additions clamp at 2^DW-1 and subtractions clamp at 0.
- R13: Every length from 1 to DEPTH works. With N = 1 the reverse walks are empty apart from the bipolar non-symmetric one, which repeats entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_mode | input | 4 | Mode bits: 0 enable, 1 symmetric, 2 bipolar, 3 continuous |
| ctrl_len_m1 | input | log2(DEPTH) | Table length minus one |
| fifo_we | input | 1 | Offset table write strobe |
| fifo_waddr | input | log2(DEPTH) | Offset table entry to write |
| fifo_wdata | input | DW | Offset value |
| in_we | input | 1 | DC level (input register) write strobe |
| in_wdata | input | DW | DC level value |
| out_we | input | 1 | Direct output register write strobe |
| out_wdata | input | DW | Direct output value |
| tick | input | 1 | Sequence update tick |
| dac_out | output | DW | DAC output code |

## Verification
The bench builds the block with DW = 8 and DEPTH = 8. The narrow code range makes clamping at both ends reachable with small offsets and DC levels near 0 and 255. The short table lets full symmetric bipolar loops run many times, and it makes the longest length (N = 8) and the single-entry case cheap to cover. The reference model builds each pattern as a list from the mode rules and checks the output every cycle. The cycles covered include those where ticks coincide with control, input and output writes.

// File: rtl/wfs_pkg.sv
package wfs_pkg;

    typedef enum logic [2:0] {
        PH_LOAD    = 3'd0,
        PH_FWD_ADD = 3'd1,
        PH_REV_ADD = 3'd2,
        PH_FWD_SUB = 3'd3,
        PH_REV_SUB = 3'd4,
        PH_DONE    = 3'd5
    } phase_e;

    typedef struct packed {
        logic cont;
        logic bip;
        logic sym;
        logic en;
    } mode_t;

    function automatic logic phase_subtracts(phase_e p);
        return (p == PH_FWD_SUB) || (p == PH_REV_SUB);
    endfunction

    function automatic logic phase_walking(phase_e p);
        return (p != PH_LOAD) && (p != PH_DONE);
    endfunction

    function automatic logic [31:0] clamp_mix(logic [31:0] base, logic [31:0] off,
                                              logic sub, logic [31:0] top);
        logic [32:0] sum;
        if (sub) begin
            return (off > base) ? 32'd0 : base - off;
        end
        sum = {1'b0, base} + {1'b0, off};
        return (sum > {1'b0, top}) ? top : sum[31:0];
    endfunction

endpackage

// File: rtl/wfs_regs.sv
module wfs_regs
    import wfs_pkg::*;
#(
    parameter int DW = 12,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctrl_we,
    input  logic [3:0]    ctrl_mode,
    input  logic [IW-1:0] ctrl_len_m1,
    input  logic          in_we,
    input  logic [DW-1:0] in_wdata,
    output mode_t         mode,
    output logic [IW-1:0] len_m1,
    output logic [DW-1:0] in_val
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= '0;
            len_m1 <= '0;
        end else if (ctrl_we) begin
            mode   <= mode_t'(ctrl_mode);
            len_m1 <= ctrl_len_m1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_val <= '0;
        end else if (in_we) begin
            in_val <= in_wdata;
        end
    end

endmodule

// File: rtl/wfs_fifo.sv
module wfs_fifo #(
    parameter int DW    = 12,
    parameter int DEPTH = 16,
    parameter int IW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lock,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] slots [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [DW-1:0] q;
        logic          hit;

        assign hit = we && !lock && (waddr == IW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (hit) begin
                q <= wdata;
            end
        end

        assign slots[g] = q;

        // R8
        locked_write_chk: assert property (@(posedge clk) disable iff (rst)
            (we && lock && (waddr == IW'(g))) |=> $stable(q));
    end

    assign rdata = slots[raddr];

endmodule

// File: rtl/wfs_stepper.sv
module wfs_stepper
    import wfs_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  mode_t         mode,
    input  logic [IW-1:0] len_m1,
    input  logic          restart,
    input  logic          tick,
    output phase_e        phase,
    output logic [IW-1:0] idx,
    output logic          emit
);

    phase_e        nxt_phase;
    logic [IW-1:0] nxt_idx;
    logic          at_end;
    logic          multi;
    logic [IW-1:0] below_last;

    assign multi      = (len_m1 != '0);
    assign below_last = len_m1 - 1'b1;
    assign emit       = tick && mode.en && !restart && (phase != PH_DONE);

    always_comb begin
        nxt_phase = phase;
        nxt_idx   = idx;
        at_end    = 1'b0;
        unique case (phase)
            PH_LOAD: begin
                nxt_phase = PH_FWD_ADD;
                nxt_idx   = '0;
            end
            PH_FWD_ADD: begin
                if (idx != len_m1) begin
                    nxt_idx = idx + 1'b1;
                end else if (mode.sym) begin
                    if (multi) begin
                        nxt_phase = PH_REV_ADD;
                        nxt_idx   = below_last;
                    end else if (mode.bip) begin
                        nxt_phase = PH_FWD_SUB;
                        nxt_idx   = '0;
                    end else begin
                        at_end = 1'b1;
                    end
                end else if (mode.bip) begin
                    nxt_phase = PH_REV_SUB;
                    nxt_idx   = len_m1;
                end else begin
                    at_end = 1'b1;
                end
            end
            PH_REV_ADD: begin
                if (idx != '0) begin
                    nxt_idx = idx - 1'b1;
                end else if (mode.bip) begin
                    nxt_phase = PH_FWD_SUB;
                    nxt_idx   = '0;
                end else begin
                    at_end = 1'b1;
                end
            end
            PH_FWD_SUB: begin
                if (idx != len_m1) begin
                    nxt_idx = idx + 1'b1;
                end else if (multi) begin
                    nxt_phase = PH_REV_SUB;
                    nxt_idx   = below_last;
                end else begin
                    at_end = 1'b1;
                end
            end
            PH_REV_SUB: begin
                if (idx != '0) begin
                    nxt_idx = idx - 1'b1;
                end else begin
                    at_end = 1'b1;
                end
            end
            default: begin
                nxt_phase = PH_DONE;
            end
        endcase

        if (at_end) begin
            if (mode.cont) begin
                nxt_phase = PH_FWD_ADD;
                nxt_idx   = (mode.sym && !mode.bip && multi) ? IW'(1) : '0;
            end else begin
                nxt_phase = PH_DONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase <= PH_LOAD;
            idx   <= '0;
        end else if (emit) begin
            phase <= nxt_phase;
            idx   <= nxt_idx;
        end
    end

    // R9
    restart_load_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (phase == PH_LOAD));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_DONE) && !restart) |=> (phase == PH_DONE));

    // R13
    idx_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        phase_walking(phase) |-> (idx <= len_m1));

endmodule

// File: rtl/wfs_out.sv
module wfs_out
    import wfs_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          emit,
    input  phase_e        phase,
    input  logic [DW-1:0] in_val,
    input  logic [DW-1:0] offset,
    input  logic          out_we,
    input  logic [DW-1:0] out_wdata,
    output logic [DW-1:0] dac_out
);

    localparam logic [31:0] CODE_TOP = 32'((64'd1 << DW) - 64'd1);

    logic [DW-1:0] step_val;

    always_comb begin
        if (phase == PH_LOAD) begin
            step_val = in_val;
        end else begin
            step_val = DW'(clamp_mix(32'(in_val), 32'(offset),
                                     phase_subtracts(phase), CODE_TOP));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_out <= '0;
        end else if (out_we) begin
            dac_out <= out_wdata;
        end else if (emit) begin
            dac_out <= step_val;
        end
    end

    // R11
    direct_write_chk: assert property (@(posedge clk) disable iff (rst)
        out_we |=> (dac_out == $past(out_wdata)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!emit && !out_we) |=> $stable(dac_out));

endmodule

// File: rtl/dac_wave_seq.sv
module dac_wave_seq
    import wfs_pkg::*;
#(
    parameter int DW    = 12,
    parameter int DEPTH = 16,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctrl_we,
    input  logic [3:0]    ctrl_mode,
    input  logic [IW-1:0] ctrl_len_m1,
    input  logic          fifo_we,
    input  logic [IW-1:0] fifo_waddr,
    input  logic [DW-1:0] fifo_wdata,
    input  logic          in_we,
    input  logic [DW-1:0] in_wdata,
    input  logic          out_we,
    input  logic [DW-1:0] out_wdata,
    input  logic          tick,
    output logic [DW-1:0] dac_out
);

    mode_t         mode;
    logic [IW-1:0] len_m1;
    logic [DW-1:0] in_val;
    logic [DW-1:0] offset;
    phase_e        phase;
    logic [IW-1:0] idx;
    logic          emit;

    wfs_regs #(.DW(DW), .IW(IW)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .ctrl_we     (ctrl_we),
        .ctrl_mode   (ctrl_mode),
        .ctrl_len_m1 (ctrl_len_m1),
        .in_we       (in_we),
        .in_wdata    (in_wdata),
        .mode        (mode),
        .len_m1      (len_m1),
        .in_val      (in_val)
    );

    wfs_fifo #(.DW(DW), .DEPTH(DEPTH), .IW(IW)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .lock  (mode.en),
        .we    (fifo_we),
        .waddr (fifo_waddr),
        .wdata (fifo_wdata),
        .raddr (idx),
        .rdata (offset)
    );

    wfs_stepper #(.IW(IW)) u_step (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .len_m1  (len_m1),
        .restart (ctrl_we),
        .tick    (tick),
        .phase   (phase),
        .idx     (idx),
        .emit    (emit)
    );

    wfs_out #(.DW(DW)) u_out (
        .clk       (clk),
        .rst       (rst),
        .emit      (emit),
        .phase     (phase),
        .in_val    (in_val),
        .offset    (offset),
        .out_we    (out_we),
        .out_wdata (out_wdata),
        .dac_out   (dac_out)
    );

endmodule

// File: tb/dac_wave_seq_tb.sv
module dac_wave_seq_tb;

    localparam int DW    = 8;
    localparam int DEPTH = 8;
    localparam int IW    = 3;
    localparam int TOP   = 255;

    logic          clk = 1'b0;
    logic          rst;
    logic          ctrl_we;
    logic [3:0]    ctrl_mode;
    logic [IW-1:0] ctrl_len_m1;
    logic          fifo_we;
    logic [IW-1:0] fifo_waddr;
    logic [DW-1:0] fifo_wdata;
    logic          in_we;
    logic [DW-1:0] in_wdata;
    logic          out_we;
    logic [DW-1:0] out_wdata;
    logic          tick;
    logic [DW-1:0] dac_out;

    always #5 clk = ~clk;

    dac_wave_seq #(.DW(DW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_mode(ctrl_mode),
        .ctrl_len_m1(ctrl_len_m1), .fifo_we(fifo_we), .fifo_waddr(fifo_waddr),
        .fifo_wdata(fifo_wdata), .in_we(in_we), .in_wdata(in_wdata),
        .out_we(out_we), .out_wdata(out_wdata), .tick(tick), .dac_out(dac_out)
    );

    // reference model state
    int    r_tab [DEPTH];
    int    r_in, r_out, r_len;
    bit    r_en, r_sym, r_bip, r_cont;
    int    pat [$];
    int    r_rs, r_pos;
    int    n_cmp = 0, n_bad = 0;
    string cur_req = "R1";
    bit    go = 1'b0;
    int    cyc = 0;
    int    v;

    function automatic int entry_val(int e);
        int k, s;
        k = e % 100;
        s = (e >= 100) ? r_in - r_tab[k] : r_in + r_tab[k];
        if (s < 0) s = 0;
        if (s > TOP) s = TOP;
        return s;
    endfunction

    task automatic build_pattern();
        int n;
        n = r_len + 1;
        pat.delete();
        for (int i = 0; i < n; i++) pat.push_back(i);
        if (r_sym) begin
            for (int i = n - 2; i >= 0; i--) pat.push_back(i);
            if (r_bip) begin
                for (int i = 0; i < n; i++) pat.push_back(100 + i);
                for (int i = n - 2; i >= 0; i--) pat.push_back(100 + i);
            end
        end else if (r_bip) begin
            for (int i = n - 1; i >= 0; i--) pat.push_back(100 + i);
        end
        r_rs  = (r_sym && !r_bip && n >= 2) ? 1 : 0;
        r_pos = -1;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) r_tab[i] = 0;
            r_in = 0; r_out = 0; r_len = 0;
            r_en = 0; r_sym = 0; r_bip = 0; r_cont = 0;
            build_pattern();
        end else begin
            if (tick && r_en && !ctrl_we && r_pos < pat.size()) begin
                if (r_pos < 0) begin
                    v = r_in;
                    r_pos = 0;
                end else begin
                    v = entry_val(pat[r_pos]);
                    r_pos++;
                    if (r_pos == pat.size() && r_cont) r_pos = r_rs;
                end
                if (!out_we) r_out = v;
            end
            if (out_we) r_out = int'(out_wdata);
            if (fifo_we && !r_en) r_tab[fifo_waddr] = int'(fifo_wdata);
            if (in_we) r_in = int'(in_wdata);
            if (ctrl_we) begin
                r_en   = ctrl_mode[0];
                r_sym  = ctrl_mode[1];
                r_bip  = ctrl_mode[2];
                r_cont = ctrl_mode[3];
                r_len  = int'(ctrl_len_m1);
                build_pattern();
            end
        end
    end

    always @(negedge clk) begin
        if (go) begin
            n_cmp++;
            if (int'(dac_out) != r_out) begin
                n_bad++;
                $display("FAIL %s: dac_out actual %0d expected %0d at cycle %0d",
                         cur_req, dac_out, r_out, cyc);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic clear_in();
        ctrl_we = 0; fifo_we = 0; in_we = 0; out_we = 0; tick = 0;
    endtask

    task automatic tick_n(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1;
        end
        @(negedge clk); clear_in();
    endtask

    task automatic do_ctrl(int m, int l, bit with_tick);
        @(negedge clk);
        ctrl_we = 1; ctrl_mode = 4'(m); ctrl_len_m1 = IW'(l); tick = with_tick;
        @(negedge clk); clear_in();
    endtask

    task automatic wr_tab(int a, int d);
        @(negedge clk);
        fifo_we = 1; fifo_waddr = IW'(a); fifo_wdata = DW'(d);
        @(negedge clk); clear_in();
    endtask

    task automatic wr_in(int d, bit with_tick);
        @(negedge clk);
        in_we = 1; in_wdata = DW'(d); tick = with_tick;
        @(negedge clk); clear_in();
    endtask

    task automatic wr_out(int d, bit with_tick);
        @(negedge clk);
        out_we = 1; out_wdata = DW'(d); tick = with_tick;
        @(negedge clk); clear_in();
    endtask

    initial begin
        rst = 1; clear_in();
        ctrl_mode = 0; ctrl_len_m1 = 0; fifo_waddr = 0; fifo_wdata = 0;
        in_wdata = 0; out_wdata = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        cur_req = "R1"; go = 1;
        @(negedge clk);

        cur_req = "R2";   // disabled ticks leave output alone
        tick_n(3);
        for (int a = 0; a < DEPTH; a++) wr_tab(a, 10 * (a + 1));
        wr_in(100, 0);

        cur_req = "R3";   // forward add, then hold
        do_ctrl(1, 3, 0); tick_n(7);

        cur_req = "R8";   // write while enabled is dropped
        wr_tab(0, 77); do_ctrl(1, 3, 0); tick_n(3);

        cur_req = "R4";
        do_ctrl(1 | 2, 3, 0); tick_n(10);

        cur_req = "R7";   // looping symmetric
        do_ctrl(1 | 2 | 8, 3, 0); tick_n(17);

        cur_req = "R5";
        wr_in(30, 0); do_ctrl(1 | 2 | 4 | 8, 3, 0); tick_n(22);

        cur_req = "R6";
        wr_in(128, 0); do_ctrl(1 | 4, 3, 0); tick_n(12);
        do_ctrl(1 | 4 | 8, 2, 0); tick_n(15);

        cur_req = "R12";  // clamp at top and bottom
        wr_in(230, 0); do_ctrl(1 | 2 | 4, 3, 0); tick_n(16);
        wr_in(5, 0); do_ctrl(1 | 4 | 8, 5, 0); tick_n(14);

        cur_req = "R13";
        wr_in(120, 0);
        do_ctrl(1 | 4 | 8, 0, 0); tick_n(6);
        do_ctrl(1 | 2 | 8, 0, 0); tick_n(4);
        do_ctrl(1 | 2 | 4 | 8, 0, 0); tick_n(5);
        do_ctrl(1 | 2 | 4 | 8, 7, 0); tick_n(40);

        cur_req = "R10";
        do_ctrl(1 | 2 | 8, 3, 0); tick_n(3);
        wr_in(60, 1); tick_n(4);
        wr_in(90, 0); tick_n(3);

        cur_req = "R11";
        wr_out(200, 0); tick_n(2);
        wr_out(17, 1); tick_n(3);
        wr_out(3, 0);

        cur_req = "R9";
        tick_n(2); do_ctrl(1 | 2 | 4 | 8, 3, 1); tick_n(5);

        cur_req = "R8";   // allowed again once disabled
        do_ctrl(0, 3, 0); wr_tab(0, 5); wr_tab(3, 250);
        do_ctrl(1 | 4, 3, 0); tick_n(10);

        repeat (2) @(negedge clk);
        go = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule